// File: doc/BRIEF.md
# Serial Receiver with Multidrop Wake-Up

This block deserializes an asynchronous serial line into 8-bit or 9-bit data words. Each frame holds one low start bit, the data bits (least significant first) and one high stop bit. The line is sampled by a 16x oversampling tick supplied by the parent. The start bit is confirmed at its midpoint, and every later bit is taken one bit time after the one before it. A finished word is presented on a valid/ready output stream, together with its ninth bit and a framing-error flag.

For buses shared by many stations, the receiver can be put to sleep. While it sleeps, received words are thrown away without raising any flag. It wakes in one of two ways, chosen by a configuration pin. In address mode, it wakes on a frame whose top data bit (the address mark) is 1, and that frame is delivered. In idle mode, it wakes when the line has stayed high for one whole frame time. On wake-up the hardware clears the sleep state by itself.

Back-pressure on the output stream works as follows. A word is held on `m_data`, `m_bit8` and `frame_err`, with `m_valid` high, until a cycle in which `m_ready` is high. A word that completes while an earlier word is still held is discarded, and the held word is kept. `m_ready` may be high in the same cycle as a new word completes; in that case the new word replaces the old one with no gap.

Top module: `uart_wake_rx`

## Requirements
- R1: In 8-bit mode (`cfg_nine`=0), a frame whose start bit is low at its midpoint (8 ticks after the falling edge) is sampled every 16 ticks after that. Its 8 data bits are put on `m_data`, first received bit at bit 0, and `m_valid` is raised.
- R2: In 9-bit mode (`cfg_nine`=1), the first eight received bits go to `m_data` and the ninth goes to `m_bit8`. A word delivered in 8-bit mode leaves `m_bit8` unchanged.
- R3: A stop bit sampled low sets `frame_err`=1 for that word. A stop bit sampled high gives `frame_err`=0.
- R4: If the line is high again at the start-bit midpoint, that start is ignored. No word is produced, and the next good frame is received correctly.
- R5: While `m_valid`=1 and `m_ready`=0, the output word stays unchanged, and a frame that completes meanwhile is discarded. `m_valid` falls after a cycle with `m_ready`=1 when no new word completes in that cycle.
- R6: A one-cycle pulse on `sleep_req` sets `asleep`=1. While asleep, a frame that does not cause a wake-up changes neither `m_valid` nor `frame_err`.
- R7: With `cfg_wake_addr`=1, the address mark is data bit 7 in 8-bit mode and data bit 8 in 9-bit mode. A frame received while asleep with the mark at 1 clears `asleep` and is delivered. A frame with the mark at 0 leaves the receiver asleep.
- R8: With `cfg_wake_addr`=0, the address mark has no effect. After 10 bit times (8-bit mode) or 11 bit times (9-bit mode) of continuous high line, `asleep` is cleared.
- R9: Reset clears `m_valid`, `frame_err` and `asleep`. Reset leaves `m_bit8` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial line; idle high |
| os_tick | input | 1 | Oversampling strobe, 16 per bit time |
| cfg_nine | input | 1 | 1 = nine data bits, 0 = eight |
| cfg_wake_addr | input | 1 | 1 = wake on address mark, 0 = wake on idle line |
| sleep_req | input | 1 | Pulse that puts the receiver to sleep |
| m_ready | input | 1 | Consumer accepts the held word |
| m_valid | output | 1 | A received word is held |
| m_data | output | 8 | Low eight data bits of the word |
| m_bit8 | output | 1 | Ninth data bit (9-bit mode) |
| frame_err | output | 1 | The held word had a low stop bit |
| asleep | output | 1 | Receiver is in sleep state |

## Verification
A table of frames covers both word lengths, good and bad stop bits, and sleeping receivers in both wake modes. The frames with value 0x80 are chosen to separate the cases: in address mode with nine bits such a frame must not wake the receiver, in address mode with eight bits an 0x81 frame must wake it, and in idle mode the same mark must be ignored. Directed runs then hold the line high just short of and just past 10 and 11 bit times, which tells apart the two idle lengths. Further runs send a short low glitch to test start-bit rejection, send two frames with no consumer to check that the first word is kept, and apply reset after a ninth bit of 1 to show that the stored bit survives.

// File: rtl/uart_wake_pkg.sv
package uart_wake_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  localparam int WORD_BITS = 9;
  localparam int FRAME_BITS_8 = 10;
  localparam int FRAME_BITS_9 = 11;
endpackage

// File: rtl/uart_wake_rx_engine.sv
module uart_wake_rx_engine
  import uart_wake_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  input  logic       nine,
  output logic       done,
  output logic [7:0] data,
  output logic       bit8,
  output logic       mark,
  output logic       stop_ok
);
  localparam int CW   = $clog2(OVERSAMPLE);
  localparam int HALF = OVERSAMPLE / 2;

  rx_state_e             state;
  logic [CW-1:0]         cnt;
  logic [3:0]            bidx;
  logic [WORD_BITS-1:0]  sr;
  logic [3:0]            last_idx;

  assign last_idx = nine ? 4'd8 : 4'd7;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      sr      <= '0;
      done    <= 1'b0;
      stop_ok <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (state)
          ST_IDLE: begin
            if (!line) begin
              state <= ST_START;
              cnt   <= '0;
            end
          end
          ST_START: begin
            if (cnt == CW'(HALF - 1)) begin
              cnt  <= '0;
              bidx <= '0;
              state <= line ? ST_IDLE : ST_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt == CW'(OVERSAMPLE - 1)) begin
              cnt <= '0;
              sr  <= {line, sr[WORD_BITS-1:1]};
              if (bidx == last_idx) state <= ST_STOP;
              else bidx <= bidx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt == CW'(OVERSAMPLE - 1)) begin
              cnt     <= '0;
              done    <= 1'b1;
              stop_ok <= line;
              state   <= ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // Shifting in from the top leaves the last received bit in sr[8] in
  // either mode, so the address mark is always that bit.
  assign data = nine ? sr[7:0] : sr[8:1];
  assign bit8 = sr[8];
  assign mark = sr[8];

  assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/uart_wake_rx_idle.sv
module uart_wake_rx_idle
  import uart_wake_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  input  logic nine,
  output logic idle_hit
);
  localparam int LIM8 = OVERSAMPLE * FRAME_BITS_8;
  localparam int LIM9 = OVERSAMPLE * FRAME_BITS_9;
  localparam int IW   = $clog2(LIM9 + 1);

  logic [IW-1:0] run;
  logic [IW-1:0] lim;

  assign lim = nine ? IW'(LIM9) : IW'(LIM8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= '0;
      idle_hit <= 1'b0;
    end else begin
      idle_hit <= 1'b0;
      if (tick) begin
        if (!line) begin
          run <= '0;
        end else if (run < lim) begin
          run <= run + 1'b1;
          if (run == lim - 1'b1) idle_hit <= 1'b1;
        end
      end
    end
  end

  assert_idle_needs_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idle_hit |-> $past(line));
endmodule

// File: rtl/uart_wake_rx_deliver.sv
module uart_wake_rx_deliver (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done,
  input  logic [7:0] data,
  input  logic       bit8,
  input  logic       mark,
  input  logic       stop_ok,
  input  logic       idle_hit,
  input  logic       nine,
  input  logic       wake_addr,
  input  logic       sleep_req,
  input  logic       m_ready,
  output logic       m_valid,
  output logic [7:0] m_data,
  output logic       m_bit8,
  output logic       frame_err,
  output logic       asleep
);
  logic wake_now;
  logic accept;
  logic load;

  assign wake_now = asleep && ((wake_addr && done && mark) || (!wake_addr && idle_hit));
  assign accept   = done && (!asleep || (wake_addr && mark));
  assign load     = accept && !(m_valid && !m_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep <= 1'b0;
    end else if (sleep_req) begin
      asleep <= 1'b1;
    end else if (wake_now) begin
      asleep <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid   <= 1'b0;
      m_data    <= '0;
      frame_err <= 1'b0;
    end else if (load) begin
      m_valid   <= 1'b1;
      m_data    <= data;
      frame_err <= !stop_ok;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  // The ninth-bit store has no reset.
  always_ff @(posedge clk) begin
    if (load && nine) m_bit8 <= bit8;
  end

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(frame_err)));

  assert_sleep_mute_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !wake_addr && done && !m_valid) |=> !m_valid);

  assert_wake_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> $past(idle_hit || (done && mark)));
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx #(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       os_tick,
  input  logic       cfg_nine,
  input  logic       cfg_wake_addr,
  input  logic       sleep_req,
  input  logic       m_ready,
  output logic       m_valid,
  output logic [7:0] m_data,
  output logic       m_bit8,
  output logic       frame_err,
  output logic       asleep
);
  logic [SYNC_STAGES-1:0] sync;
  logic       line_s;
  logic       done;
  logic [7:0] data;
  logic       bit8;
  logic       mark;
  logic       stop_ok;
  logic       idle_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '1;
    else        sync <= {sync[SYNC_STAGES-2:0], rx_line};
  end
  assign line_s = sync[SYNC_STAGES-1];

  uart_wake_rx_engine #(.OVERSAMPLE(OVERSAMPLE)) u_engine (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line_s), .nine(cfg_nine),
    .done(done), .data(data), .bit8(bit8), .mark(mark), .stop_ok(stop_ok)
  );

  uart_wake_rx_idle #(.OVERSAMPLE(OVERSAMPLE)) u_idle (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line_s), .nine(cfg_nine),
    .idle_hit(idle_hit)
  );

  uart_wake_rx_deliver u_deliver (
    .clk(clk), .rst_n(rst_n), .done(done), .data(data), .bit8(bit8),
    .mark(mark), .stop_ok(stop_ok), .idle_hit(idle_hit), .nine(cfg_nine),
    .wake_addr(cfg_wake_addr), .sleep_req(sleep_req), .m_ready(m_ready),
    .m_valid(m_valid), .m_data(m_data), .m_bit8(m_bit8),
    .frame_err(frame_err), .asleep(asleep)
  );
endmodule

// File: tb/uart_wake_rx_bench.sv
module uart_wake_rx_bench;
  localparam int BIT = 32;  // clocks per bit: tick every second clock, 16 ticks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_line = 1'b1;
  logic os_tick = 1'b0;
  logic cfg_nine = 1'b0;
  logic cfg_wake_addr = 1'b0;
  logic sleep_req = 1'b0;
  logic m_ready = 1'b0;
  logic m_valid;
  logic [7:0] m_data;
  logic m_bit8;
  logic frame_err;
  logic asleep;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;
  always @(posedge clk) os_tick <= ~os_tick;

  uart_wake_rx u_uart_wake_rx (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
    .cfg_nine(cfg_nine), .cfg_wake_addr(cfg_wake_addr), .sleep_req(sleep_req),
    .m_ready(m_ready), .m_valid(m_valid), .m_data(m_data), .m_bit8(m_bit8),
    .frame_err(frame_err), .asleep(asleep)
  );

  // {nine, wake_addr, sleep, word[8:0], stop, exp_valid, exp_data, exp_b8, exp_err, exp_asleep}
  localparam logic [24:0] VEC [10] = '{
    {1'b0, 1'b0, 1'b0, 9'h0A5, 1'b1, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b0, 1'b0, 9'h03C, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b1, 1'b0},
    {1'b1, 1'b0, 1'b0, 9'h15A, 1'b1, 1'b1, 8'h5A, 1'b1, 1'b0, 1'b0},
    {1'b1, 1'b0, 1'b0, 9'h0FF, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b1, 9'h07F, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1},
    {1'b0, 1'b1, 1'b1, 9'h081, 1'b1, 1'b1, 8'h81, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b1, 1'b1, 9'h080, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1},
    {1'b1, 1'b1, 1'b1, 9'h101, 1'b1, 1'b1, 8'h01, 1'b1, 1'b0, 1'b0},
    {1'b0, 1'b0, 1'b1, 9'h080, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1},
    {1'b1, 1'b0, 1'b1, 9'h1C3, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    rx_line = 1'b1;
    sleep_req = 1'b0;
    m_ready = 1'b0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(1);
  endtask

  task automatic pulse_sleep();
    @(negedge clk);
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  task automatic pulse_ready();
    @(negedge clk);
    m_ready = 1'b1;
    @(negedge clk);
    m_ready = 1'b0;
  endtask

  task automatic send(input logic [8:0] w, input logic nine, input logic stop);
    rx_line = 1'b0;
    wait_clk(BIT);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      rx_line = w[i];
      wait_clk(BIT);
    end
    rx_line = stop;
    // a low stop is held only past its midpoint, then the line returns high
    wait_clk(stop ? BIT : 20);
    rx_line = 1'b1;
    wait_clk(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    do_reset();
    chk("R9 reset m_valid", 32'(m_valid), 0);
    chk("R9 reset asleep", 32'(asleep), 0);
    chk("R9 reset frame_err", 32'(frame_err), 0);

    // table: R1 R2 R3 R6 R7 R8
    for (int v = 0; v < 10; v++) begin
      logic [24:0] e;
      e = VEC[v];
      do_reset();
      cfg_nine = e[24];
      cfg_wake_addr = e[23];
      if (e[22]) pulse_sleep();
      send(e[21:13], e[24], e[12]);
      chk($sformatf("R1 R6 R7 vec %0d m_valid", v), 32'(m_valid), 32'(e[11]));
      if (e[11]) chk($sformatf("R1 R2 vec %0d m_data", v), 32'(m_data), 32'(e[10:3]));
      if (e[11] && e[24]) chk($sformatf("R2 vec %0d m_bit8", v), 32'(m_bit8), 32'(e[2]));
      chk($sformatf("R3 R6 vec %0d frame_err", v), 32'(frame_err), 32'(e[1]));
      chk($sformatf("R7 R8 vec %0d asleep", v), 32'(asleep), 32'(e[0]));
      pulse_ready();
      chk($sformatf("R5 vec %0d m_valid after ready", v), 32'(m_valid), 0);
    end

    // R8: idle wake-up length, 8-bit mode (10 bit times = 320 clocks)
    cfg_nine = 1'b0; cfg_wake_addr = 1'b0;
    do_reset();
    pulse_sleep();
    wait_clk(296);
    chk("R8 8-bit still asleep before 10 bits", 32'(asleep), 1);
    wait_clk(40);
    chk("R8 8-bit awake after 10 bits", 32'(asleep), 0);

    // R8: 9-bit mode needs 11 bit times (352 clocks)
    cfg_nine = 1'b1;
    do_reset();
    pulse_sleep();
    wait_clk(328);
    chk("R8 9-bit still asleep at 10.3 bits", 32'(asleep), 1);
    wait_clk(40);
    chk("R8 9-bit awake after 11 bits", 32'(asleep), 0);

    // R4: false start glitch
    cfg_nine = 1'b0;
    do_reset();
    rx_line = 1'b0;
    wait_clk(6);
    rx_line = 1'b1;
    wait_clk(100);
    chk("R4 glitch no word", 32'(m_valid), 0);
    send(9'h05A, 1'b0, 1'b1);
    chk("R4 next frame valid", 32'(m_valid), 1);
    chk("R4 next frame data", 32'(m_data), 32'h5A);

    // R5: back-pressure keeps the first word
    do_reset();
    send(9'h011, 1'b0, 1'b1);
    send(9'h022, 1'b0, 1'b1);
    chk("R5 held valid", 32'(m_valid), 1);
    chk("R5 first word kept", 32'(m_data), 32'h11);
    pulse_ready();
    chk("R5 drop after ready", 32'(m_valid), 0);

    // R2/R9: ninth bit storage
    cfg_nine = 1'b1;
    do_reset();
    send(9'h10F, 1'b1, 1'b1);
    chk("R2 ninth bit stored", 32'(m_bit8), 1);
    pulse_ready();
    cfg_nine = 1'b0;
    send(9'h000, 1'b0, 1'b1);
    chk("R2 8-bit word data", 32'(m_data), 0);
    chk("R2 8-bit word keeps m_bit8", 32'(m_bit8), 1);
    do_reset();
    chk("R9 reset keeps m_bit8", 32'(m_bit8), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule